// File: doc/BRIEF.md
# Digital I/O Controller with Change-of-State Interrupts

This block is the register core of a 56-line digital I/O card. It drives 24 output-only lines and reads 24 isolated input-only lines. It also has an 8-line TTL port whose direction software selects. Software reaches it through a small byte-wide bus: a 4-bit address, 8-bit write and read data, and one write strobe and one read strobe. Every output register reads back the value it is driving, so software can change single bits by read-modify-write.

All input pins pass through multi-flop synchronizers. The synchronized lines are grouped into four 8-bit banks: three banks of isolated inputs, and the TTL lines as the fourth bank. Each bank has its own rising-edge enable and falling-edge enable. An enabled edge latches into a per-line status bit, and software clears a status bit by writing a 1 to it. A level interrupt output stays high while any status bit is set. A write to the reset register returns the block to its power-on state.

Top module: `dio_cos_ctrl`

## Requirements
- R1: After reset, out_o is 0, ttl_oe_o is 0, irq_o is 0, and the enable register (offset 14) and all status bytes (offsets 8 to 11) read 0.
- R2: Writing offset k (k = 0, 1, 2) drives out_o[8k+7:8k]. Reading offset k returns that driven byte.
- R3: Offsets 4, 5 and 6 read the synchronized in_i[7:0], in_i[15:8] and in_i[23:16]. Writes to offsets 4 to 7 change neither out_o, nor ttl_o, nor what those offsets read.
- R4: Bit 1 of the control register (offset 12) sets ttl_oe_o. ttl_o drives the byte at offset 3, and offset 3 reads that byte back. Offset 12 reads bit 1 only, and offset 7 reads the synchronized ttl_i.
- R5: Inputs pass through a two-flop synchronizer followed by a one-cycle history register. A pin change therefore sets its status bit at the third rising clock edge after the change, and not before.
- R6: In the enable register (offset 14), bit b enables rising edges and bit b+4 enables falling edges for bank b. Banks 0 to 2 are in_i[7:0], in_i[15:8] and in_i[23:16], and bank 3 is ttl_i. An edge that is not enabled sets no status bit.
- R7: Status offsets 8 to 11 hold banks 0 to 3. A write clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0.
- R8: irq_o is 1 exactly while any status bit is set. Offset 15 reads irq_o in bit 0.
- R9: When an enabled edge and a clear hit the same status bit in the same cycle, the bit stays set.
- R10: A write to offset 15 with any data clears out_o, ttl_o, the control register, the enable register and all status bits.
- R11: Offset 13 reads 0, and a write to it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe; rdata_o updates at the next edge |
| rdata_o | output | 8 | Read data, held until the next read |
| out_o | output | 24 | Output-only lines |
| in_i | input | 24 | Isolated input lines (asynchronous) |
| ttl_o | output | 8 | TTL port output value |
| ttl_i | input | 8 | TTL port pad value (asynchronous) |
| ttl_oe_o | output | 1 | TTL port output enable |
| irq_o | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value the pin-to-status latency is exactly three edges, so the bench can place a clear write on the very edge where a falling edge sets the same bit, and can check that the set wins. The same fixed latency lets it confirm that no status appears one edge after a pin change. The 8-bit bank width lets one write cover a whole bank, so enable and clear patterns can be mixed across all four banks, the TTL bank included.

// File: rtl/dio_pkg.sv
`timescale 1ns/1ps
package dio_pkg;
  localparam int BANK_W      = 8;
  localparam int N_OUT_BANKS = 3;
  localparam int N_IN_BANKS  = 3;
  localparam int N_COS_BANKS = N_IN_BANKS + 1;
  localparam int OUT_W       = N_OUT_BANKS * BANK_W;
  localparam int IN_W        = N_IN_BANKS * BANK_W;
  localparam int COS_W       = N_COS_BANKS * BANK_W;
  localparam int EN_W        = 2 * N_COS_BANKS;
  localparam int ADDR_W      = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BANK_W-1:0] byte_t;

  localparam addr_t ADR_OUT0    = 4'd0;
  localparam addr_t ADR_TTL_OUT = 4'd3;
  localparam addr_t ADR_IN0     = 4'd4;
  localparam addr_t ADR_TTL_IN  = 4'd7;
  localparam addr_t ADR_COS0    = 4'd8;
  localparam addr_t ADR_CTL     = 4'd12;
  localparam addr_t ADR_COS_EN  = 4'd14;
  localparam addr_t ADR_SRST    = 4'd15;
  localparam int    CTL_TTL_OUT_BIT = 1;
endpackage

// File: rtl/dio_sync.sv
`timescale 1ns/1ps
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dio_cos_bank.sv
`timescale 1ns/1ps
module dio_cos_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         rise_en_i,
  input  logic         fall_en_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic         srst_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, status_q, set_vec, clr_eff;

  // history keeps running across soft reset; enables are cleared there anyway
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign set_vec = (lvl_i & ~prev_q & {W{rise_en_i}})
                 | (~lvl_i & prev_q & {W{fall_en_i}});
  assign clr_eff = clr_i ? clr_mask_i : '0;

  // set beats clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_q <= '0;
    else if (srst_i) status_q <= '0;
    else             status_q <= (status_q & ~clr_eff) | set_vec;
  end

  assign status_o = status_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && (|set_vec)) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && clr_i) |=> ((status_q & $past(clr_mask_i & ~set_vec)) == '0));

  a_r10_srst_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (status_q == '0));

  a_r6_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_en_i && !fall_en_i && !clr_i && !srst_i) |=> $stable(status_q));
endmodule

// File: rtl/dio_regfile.sv
`timescale 1ns/1ps
module dio_regfile
  import dio_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  addr_t                  addr_i,
  input  byte_t                  wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [IN_W-1:0]        in_sync_i,
  input  byte_t                  ttl_sync_i,
  input  logic [COS_W-1:0]       status_i,
  input  logic                   irq_i,
  output byte_t                  rdata_o,
  output logic [OUT_W-1:0]       out_o,
  output byte_t                  ttl_out_o,
  output logic                   ttl_oe_o,
  output logic [EN_W-1:0]        cos_en_o,
  output logic [N_COS_BANKS-1:0] cos_clr_o,
  output byte_t                  clr_mask_o,
  output logic                   srst_o
);
  logic [OUT_W-1:0] out_q;
  byte_t            ttl_out_q, rd_mux, rdata_q;
  logic             ttl_mode_q;
  logic [EN_W-1:0]  cos_en_q;

  assign srst_o = wr_i && (addr_i == ADR_SRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q      <= '0;
      ttl_out_q  <= '0;
      ttl_mode_q <= 1'b0;
      cos_en_q   <= '0;
    end else if (srst_o) begin
      out_q      <= '0;
      ttl_out_q  <= '0;
      ttl_mode_q <= 1'b0;
      cos_en_q   <= '0;
    end else if (wr_i) begin
      for (int k = 0; k < N_OUT_BANKS; k++)
        if (addr_i == ADR_OUT0 + ADDR_W'(k)) out_q[k*BANK_W +: BANK_W] <= wdata_i;
      if (addr_i == ADR_TTL_OUT) ttl_out_q  <= wdata_i;
      if (addr_i == ADR_CTL)     ttl_mode_q <= wdata_i[CTL_TTL_OUT_BIT];
      if (addr_i == ADR_COS_EN)  cos_en_q   <= wdata_i[EN_W-1:0];
    end
  end

  always_comb begin
    for (int b = 0; b < N_COS_BANKS; b++)
      cos_clr_o[b] = wr_i && (addr_i == ADR_COS0 + ADDR_W'(b));
  end
  assign clr_mask_o = wdata_i;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_OUT_BANKS; k++)
      if (addr_i == ADR_OUT0 + ADDR_W'(k)) rd_mux = out_q[k*BANK_W +: BANK_W];
    for (int k = 0; k < N_IN_BANKS; k++)
      if (addr_i == ADR_IN0 + ADDR_W'(k)) rd_mux = in_sync_i[k*BANK_W +: BANK_W];
    for (int b = 0; b < N_COS_BANKS; b++)
      if (addr_i == ADR_COS0 + ADDR_W'(b)) rd_mux = status_i[b*BANK_W +: BANK_W];
    if (addr_i == ADR_TTL_OUT) rd_mux = ttl_out_q;
    if (addr_i == ADR_TTL_IN)  rd_mux = ttl_sync_i;
    if (addr_i == ADR_CTL)     rd_mux[CTL_TTL_OUT_BIT] = ttl_mode_q;
    if (addr_i == ADR_COS_EN)  rd_mux[EN_W-1:0] = cos_en_q;
    if (addr_i == ADR_SRST)    rd_mux[0] = irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign out_o     = out_q;
  assign ttl_out_o = ttl_out_q;
  assign ttl_oe_o  = ttl_mode_q;
  assign cos_en_o  = cos_en_q;

  a_r10_srst_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (out_q == '0 && ttl_out_q == '0 && !ttl_mode_q && cos_en_q == '0));

  a_r3_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i >= ADR_IN0 && addr_i <= ADR_TTL_IN) |=>
      ($stable(out_q) && $stable(ttl_out_q)));

  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(out_q));
endmodule

// File: rtl/dio_cos_ctrl.sv
`timescale 1ns/1ps
module dio_cos_ctrl
  import dio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BANK_W-1:0]    wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [BANK_W-1:0]    rdata_o,
  output logic [OUT_W-1:0]     out_o,
  input  logic [IN_W-1:0]      in_i,
  output logic [BANK_W-1:0]    ttl_o,
  input  logic [BANK_W-1:0]    ttl_i,
  output logic                 ttl_oe_o,
  output logic                 irq_o
);
  logic [COS_W-1:0]       pins_sync, status_all;
  logic [EN_W-1:0]        cos_en;
  logic [N_COS_BANKS-1:0] cos_clr;
  byte_t                  clr_mask;
  logic                   srst;

  dio_sync #(.W(COS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ttl_i, in_i}),
    .q_o   (pins_sync)
  );

  for (genvar b = 0; b < N_COS_BANKS; b++) begin : g_bank
    dio_cos_bank #(.W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (pins_sync[b*BANK_W +: BANK_W]),
      .rise_en_i (cos_en[b]),
      .fall_en_i (cos_en[b+N_COS_BANKS]),
      .clr_i     (cos_clr[b]),
      .clr_mask_i(clr_mask),
      .srst_i    (srst),
      .status_o  (status_all[b*BANK_W +: BANK_W])
    );
  end

  assign irq_o = |status_all;

  dio_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .in_sync_i (pins_sync[IN_W-1:0]),
    .ttl_sync_i(pins_sync[COS_W-1:IN_W]),
    .status_i  (status_all),
    .irq_i     (irq_o),
    .rdata_o   (rdata_o),
    .out_o     (out_o),
    .ttl_out_o (ttl_o),
    .ttl_oe_o  (ttl_oe_o),
    .cos_en_o  (cos_en),
    .cos_clr_o (cos_clr),
    .clr_mask_o(clr_mask),
    .srst_o    (srst)
  );
endmodule

// File: tb/dio_cos_ctrl_tb_top.sv
`timescale 1ns/1ps
module dio_cos_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [23:0] out, in_pins = '0;
  logic [7:0]  ttl_out, ttl_pins = '0;
  logic        ttl_oe, irq;
  int          n_chk = 0, n_err = 0;
  logic        timeout = 1'b0;

  always #2.5 clk = ~clk;

  dio_cos_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .out_o(out), .in_i(in_pins),
    .ttl_o(ttl_out), .ttl_i(ttl_pins), .ttl_oe_o(ttl_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 out_o", out, 0);
    chk("R1 ttl_oe_o", ttl_oe, 0);
    chk("R1 irq_o", irq, 0);
    bus_rd(4'd14, d); chk("R1 enable reg", d, 0);
    bus_rd(4'd8, d);  chk("R1 status bank0", d, 0);
    bus_rd(4'd11, d); chk("R1 status bank3", d, 0);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    bus_wr(4'd0, 8'hA5); bus_wr(4'd1, 8'h3C); bus_wr(4'd2, 8'hF0);
    chk("R2 out_o drive", out, 24'hF03CA5);
    bus_rd(4'd1, d); chk("R2 readback off1", d, 8'h3C);
    bus_rd(4'd2, d); chk("R2 readback off2", d, 8'hF0);
  endtask

  task automatic t_inputs();
    logic [7:0] d;
    in_pins = 24'h123456; settle();
    bus_rd(4'd4, d); chk("R3 in byte0", d, 8'h56);
    bus_rd(4'd6, d); chk("R3 in byte2", d, 8'h12);
    bus_wr(4'd4, 8'hFF); bus_wr(4'd7, 8'hFF);
    chk("R3 out_o after ro write", out, 24'hF03CA5);
    chk("R3 ttl_o after ro write", ttl_out, 0);
    bus_rd(4'd4, d); chk("R3 in byte0 after write", d, 8'h56);
    bus_wr(4'd13, 8'hFF);
    bus_rd(4'd13, d); chk("R11 reserved reads 0", d, 0);
    chk("R11 out_o unchanged", out, 24'hF03CA5);
  endtask

  task automatic t_ttl();
    logic [7:0] d;
    bus_wr(4'd3, 8'h5A);
    chk("R4 oe off in input mode", ttl_oe, 0);
    bus_wr(4'd12, 8'hFF);
    chk("R4 oe on", ttl_oe, 1);
    chk("R4 ttl_o value", ttl_out, 8'h5A);
    bus_rd(4'd3, d);  chk("R4 ttl out readback", d, 8'h5A);
    bus_rd(4'd12, d); chk("R4 ctl reads bit1 only", d, 8'h02);
    ttl_pins = 8'hC3; settle();
    bus_rd(4'd7, d); chk("R4 ttl input byte", d, 8'hC3);
    bus_wr(4'd12, 8'h00);
    chk("R4 oe off again", ttl_oe, 0);
  endtask

  task automatic t_cos();
    logic [7:0] d;
    in_pins = '0; settle();
    bus_rd(4'd8, d);  chk("R6 no status while disabled", d, 0);
    bus_rd(4'd11, d); chk("R6 no ttl status while disabled", d, 0);
    bus_wr(4'd14, 8'h01);
    @(negedge clk); in_pins = 24'h000001;
    @(negedge clk); chk("R5 no status after one edge", irq, 0);
    @(negedge clk); chk("R5 no status after two edges", irq, 0);
    @(negedge clk); chk("R5 status after three edges", irq, 1);
    bus_rd(4'd8, d);  chk("R6 rise bank0", d, 8'h01);
    chk("R8 irq high", irq, 1);
    bus_rd(4'd15, d); chk("R8 irq readback", d, 8'h01);
    in_pins = '0; settle();
    bus_rd(4'd8, d);  chk("R6 fall disabled", d, 8'h01);
    bus_wr(4'd8, 8'h00);
    bus_rd(4'd8, d);  chk("R7 zero leaves bit", d, 8'h01);
    bus_wr(4'd8, 8'h01);
    bus_rd(4'd8, d);  chk("R7 one clears bit", d, 0);
    chk("R8 irq low", irq, 0);
    bus_rd(4'd15, d); chk("R8 irq readback low", d, 0);
    bus_wr(4'd14, 8'h28);
    in_pins = 24'h000100; settle();
    bus_rd(4'd9, d);  chk("R6 rise ignored bank1", d, 0);
    in_pins = 24'h000000; ttl_pins = 8'hC7; settle();
    bus_rd(4'd9, d);  chk("R6 fall bank1", d, 8'h01);
    bus_rd(4'd11, d); chk("R6 rise ttl bank3", d, 8'h04);
    bus_rd(4'd10, d); chk("R6 bank2 quiet", d, 0);
    bus_wr(4'd9, 8'hFF);
    chk("R8 irq held by bank3", irq, 1);
    bus_wr(4'd11, 8'hFF);
    chk("R8 irq low after all clear", irq, 0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    bus_wr(4'd14, 8'h11);
    in_pins = 24'h000001; settle();
    bus_rd(4'd8, d); chk("R9 setup rise", d, 8'h01);
    @(negedge clk); in_pins = 24'h000000;
    @(negedge clk);
    @(negedge clk); addr = 4'd8; wdata = 8'h01; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    bus_rd(4'd8, d); chk("R9 set beats clear", d, 8'h01);
    bus_wr(4'd8, 8'h01);
    bus_rd(4'd8, d); chk("R9 later clear works", d, 0);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    bus_wr(4'd0, 8'h77); bus_wr(4'd3, 8'h99); bus_wr(4'd12, 8'h02);
    bus_wr(4'd14, 8'hFF);
    in_pins = 24'h000001; settle();
    chk("R10 setup irq", irq, 1);
    bus_wr(4'd15, 8'h00);
    chk("R10 out_o cleared", out, 0);
    chk("R10 ttl_o cleared", ttl_out, 0);
    chk("R10 ttl_oe cleared", ttl_oe, 0);
    chk("R10 irq cleared", irq, 0);
    bus_rd(4'd14, d); chk("R10 enable cleared", d, 0);
    bus_rd(4'd8, d);  chk("R10 status cleared", d, 0);
    bus_rd(4'd12, d); chk("R10 ctl cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_outputs();
        t_inputs();
        t_ttl();
        t_cos();
        t_set_wins();
        t_soft_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule